// File: doc/BRIEF.md
# Page Write Engine with Self-Timed Busy Cycle

This block takes the data phase of a serial memory write transaction. When a write is started with the write-enable state set, it keeps the page part of the start address and loads a six-bit in-page offset from it. Every received byte goes into a page buffer at the current offset, and the offset then steps forward. The offset wraps inside the page, so a long burst overwrites bytes it stored earlier. If the write is started while write-enable is clear, the block ignores the whole transaction.

The page is committed only when chip-select rises exactly on a byte boundary, and only if at least one byte was stored. After a commit the block raises a busy flag for a fixed number of clock cycles. While busy, it walks the buffer in ascending offset order. For each received offset it asks an external per-address protection check, and it strobes a write to the array when the address is not protected. In the last busy cycle it pulses a request that clears the write-enable latch. While busy, any new start, byte or chip-select event is ignored.

Top module: `pw_page_writer`

## Requirements
- R1: A start with `wen` low is ignored: the bytes and the chip-select rise that follow produce no array write, no busy cycle and no `wen_clear` pulse.
- R2: The first byte is stored at offset `wr_addr[5:0]`. Each further byte goes to the previous offset plus one, modulo 64. The array address is the start address's bits [14:6] concatenated with that offset.
- R3: When more than 64 bytes arrive, the offset wraps and only the last byte received for each offset is written.
- R4: A commit happens only when `cs_rise` is high with `cs_on_byte_edge` high and at least one byte has been received. Any other chip-select rise returns the block to idle with nothing written.
- R5: `busy` goes high in the cycle after the committing `cs_rise` and stays high for exactly `BUSY_CYCLES` cycles.
- R6: During busy, each received offset is written exactly once, in ascending offset order. Offsets that were not received are never written.
- R7: No array write is issued while `prot_blocked` is high for the address shown on `prot_addr`.
- R8: `wen_clear` is a single-cycle pulse in the last busy cycle, and it occurs once per commit.
- R9: A start, data bytes or chip-select rises during busy change neither the busy length nor the writes, and they start no new transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_start | input | 1 | Write instruction accepted, address valid |
| wr_addr | input | ADDR_W | Starting byte address |
| byte_valid | input | 1 | A data byte has been received |
| byte_data | input | 8 | Received data byte |
| cs_rise | input | 1 | Chip-select rising event |
| cs_on_byte_edge | input | 1 | The chip-select rise came right after a complete byte |
| wen | input | 1 | Write-enable latch state |
| prot_addr | output | ADDR_W | Address being checked for protection |
| prot_blocked | input | 1 | The address on prot_addr is protected |
| arr_we | output | 1 | Array write strobe |
| arr_addr | output | ADDR_W | Array write address |
| arr_wdata | output | 8 | Array write data |
| busy | output | 1 | Self-timed write cycle in progress |
| wen_clear | output | 1 | Pulse that clears the write-enable latch |

## Verification
Some properties are checked on every cycle. The assertions check that a busy period starts only after a boundary-aligned chip-select rise and that the page stays frozen while busy. They also check that writes inside a busy period rise strictly in address, that they occur only while busy, and that `wen_clear` is a lone pulse that ends the busy period. Other behaviour can only be shown by the bench's scenarios. These are the exact busy length, the last-byte-wins contents after a wrap, the write count for each offset, protection masking at chosen limits, and the ignoring of disabled or misaligned transactions. The bench covers them with a sweep over start offsets, burst lengths and protection limits.

// File: rtl/pw_pkg.sv
package pw_pkg;
    typedef enum logic [1:0] {
        PW_IDLE    = 2'd0,
        PW_COLLECT = 2'd1,
        PW_BUSY    = 2'd2
    } pw_state_e;
endpackage

// File: rtl/pw_page_buffer.sv
module pw_page_buffer #(
    parameter int DATA_W = 8,
    parameter int IDX_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);
    localparam int DEPTH = 1 << IDX_W;

    typedef struct packed {
        logic [DEPTH-1:0][DATA_W-1:0] mem;
        logic [DEPTH-1:0]             vld;
    } buf_t;

    buf_t buf_d, buf_q;

    always_comb begin
        buf_d = buf_q;
        if (clr) begin
            buf_d.vld = '0;
        end else if (wr_en) begin
            buf_d.mem[wr_idx] = wr_data;
            buf_d.vld[wr_idx] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) buf_q <= '0;
        else        buf_q <= buf_d;
    end

    assign rd_data  = buf_q.mem[rd_idx];
    assign rd_valid = buf_q.vld[rd_idx];

    // a cleared buffer holds no valid entry on the next cycle (R6)
    assert_clear_empties_R6: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (buf_q.vld == '0));
endmodule

// File: rtl/pw_busy_timer.sv
module pw_busy_timer #(
    parameter int CYCLES = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic run,
    output logic last
);
    localparam int CNT_W = $clog2(CYCLES + 1);
    localparam logic [CNT_W-1:0] INIT = CNT_W'(CYCLES - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (load)                       tmr_d.cnt = INIT;
        else if (run && tmr_q.cnt != 0) tmr_d.cnt = tmr_q.cnt - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign last = run && (tmr_q.cnt == '0);

    // counter steps down by one on each running cycle (R5)
    assert_count_down_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !load && tmr_q.cnt != 0) |=> (tmr_q.cnt == $past(tmr_q.cnt) - 1'b1));
endmodule

// File: rtl/pw_page_writer.sv
module pw_page_writer
    import pw_pkg::*;
#(
    parameter int ADDR_W      = 15,
    parameter int PAGE_BITS   = 6,
    parameter int BUSY_CYCLES = 100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_start,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              byte_valid,
    input  logic [7:0]        byte_data,
    input  logic              cs_rise,
    input  logic              cs_on_byte_edge,
    input  logic              wen,
    output logic [ADDR_W-1:0] prot_addr,
    input  logic              prot_blocked,
    output logic              arr_we,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [7:0]        arr_wdata,
    output logic              busy,
    output logic              wen_clear
);
    localparam int PAGE_W     = ADDR_W - PAGE_BITS;
    localparam int PAGE_BYTES = 1 << PAGE_BITS;

    if (BUSY_CYCLES < PAGE_BYTES) begin : g_bad_len
        $error("BUSY_CYCLES must cover one full page scan");
    end

    typedef struct packed {
        pw_state_e            st;
        logic [PAGE_W-1:0]    page;
        logic [PAGE_BITS-1:0] off;
        logic [PAGE_BITS:0]   scan;
        logic                 got;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic                 buf_clr, buf_wr;
    logic [7:0]           rd_data;
    logic                 rd_valid;
    logic                 tmr_load, tmr_last;
    logic [PAGE_BITS-1:0] scan_idx;

    assign scan_idx = ctl_q.scan[PAGE_BITS-1:0];

    always_comb begin
        ctl_d    = ctl_q;
        buf_clr  = 1'b0;
        buf_wr   = 1'b0;
        tmr_load = 1'b0;
        unique case (ctl_q.st)
            PW_IDLE: begin
                if (wr_start && wen) begin
                    ctl_d.st   = PW_COLLECT;
                    ctl_d.page = wr_addr[ADDR_W-1:PAGE_BITS];
                    ctl_d.off  = wr_addr[PAGE_BITS-1:0];
                    ctl_d.got  = 1'b0;
                    buf_clr    = 1'b1;
                end
            end
            PW_COLLECT: begin
                if (byte_valid) begin
                    buf_wr     = 1'b1;
                    ctl_d.off  = ctl_q.off + 1'b1;
                    ctl_d.got  = 1'b1;
                end
                if (cs_rise) begin
                    if (cs_on_byte_edge && (ctl_q.got || byte_valid)) begin
                        ctl_d.st   = PW_BUSY;
                        ctl_d.scan = '0;
                        tmr_load   = 1'b1;
                    end else begin
                        ctl_d.st = PW_IDLE;
                    end
                end
            end
            PW_BUSY: begin
                if (!ctl_q.scan[PAGE_BITS]) ctl_d.scan = ctl_q.scan + 1'b1;
                if (tmr_last)               ctl_d.st   = PW_IDLE;
            end
            default: ctl_d.st = PW_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '{st: PW_IDLE, default: '0};
        else        ctl_q <= ctl_d;
    end

    pw_page_buffer #(.DATA_W(8), .IDX_W(PAGE_BITS)) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (buf_clr),
        .wr_en   (buf_wr),
        .wr_idx  (ctl_q.off),
        .wr_data (byte_data),
        .rd_idx  (scan_idx),
        .rd_data (rd_data),
        .rd_valid(rd_valid)
    );

    pw_busy_timer #(.CYCLES(BUSY_CYCLES)) u_tmr (
        .clk  (clk),
        .rst_n(rst_n),
        .load (tmr_load),
        .run  (ctl_q.st == PW_BUSY),
        .last (tmr_last)
    );

    assign busy      = (ctl_q.st == PW_BUSY);
    assign prot_addr = {ctl_q.page, scan_idx};
    assign arr_addr  = prot_addr;
    assign arr_wdata = rd_data;
    assign arr_we    = busy && !ctl_q.scan[PAGE_BITS] && rd_valid && !prot_blocked;
    assign wen_clear = tmr_last;

    // busy starts only from a boundary-aligned chip-select rise (R4)
    assert_commit_on_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(cs_rise && cs_on_byte_edge));
    // array writes happen only inside the busy window (R6)
    assert_write_in_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> busy);
    // successive writes ascend within one busy period (R6)
    assert_ascending_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_we && $past(busy) && busy) |-> ($past(arr_addr) < arr_addr || !$past(arr_we)));
    // page is frozen while busy, new starts do not disturb it (R9)
    assert_page_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(ctl_q.page));
    // wen_clear is a lone pulse (R8)
    assert_clear_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wen_clear |=> !wen_clear);
    // busy ends right after the clear pulse (R8)
    assert_clear_ends_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(wen_clear));
endmodule

// File: tb/pw_page_writer_tb.sv
module pw_page_writer_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 15;
    localparam int BUSY       = 100;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_start = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic              byte_valid = 1'b0;
    logic [7:0]        byte_data = '0;
    logic              cs_rise = 1'b0;
    logic              cs_on_byte_edge = 1'b0;
    logic              wen = 1'b0;
    logic [ADDR_W-1:0] prot_addr;
    logic              prot_blocked;
    logic              arr_we;
    logic [ADDR_W-1:0] arr_addr;
    logic [7:0]        arr_wdata;
    logic              busy;
    logic              wen_clear;

    logic [15:0] prot_limit = 16'h8000;
    assign prot_blocked = ({1'b0, prot_addr} >= prot_limit);

    always #(CLK_PERIOD/2) clk = ~clk;

    pw_page_writer #(.ADDR_W(ADDR_W), .PAGE_BITS(6), .BUSY_CYCLES(BUSY)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_start(wr_start), .wr_addr(wr_addr),
        .byte_valid(byte_valid), .byte_data(byte_data), .cs_rise(cs_rise),
        .cs_on_byte_edge(cs_on_byte_edge), .wen(wen), .prot_addr(prot_addr),
        .prot_blocked(prot_blocked), .arr_we(arr_we), .arr_addr(arr_addr),
        .arr_wdata(arr_wdata), .busy(busy), .wen_clear(wen_clear)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    logic [7:0] exp_val [64];
    bit         exp_vld [64];
    bit         seen    [64];
    logic [8:0] exp_page;
    int wr_cnt, busy_cnt, clr_cnt;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int run, input int k);
        return 8'((k * 37 + run * 11 + 5) & 255);
    endfunction

    // monitor away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (busy) busy_cnt++;
            if (wen_clear) clr_cnt++;
            if (arr_we) begin
                automatic int o = int'(arr_addr[5:0]);
                wr_cnt++;
                check(arr_addr[14:6] == exp_page, "R2 page", int'(arr_addr[14:6]), int'(exp_page));
                check(exp_vld[o] && !seen[o], "R6 offset once", o, o);
                check(arr_wdata == exp_val[o], "R3 data", int'(arr_wdata), int'(exp_val[o]));
                check({1'b0, arr_addr} < prot_limit, "R7 protected", int'(arr_addr), int'(prot_limit));
                seen[o] = 1'b1;
            end
        end
    end

    int run_id = 0;

    task automatic run(input int off, input int page, input int n, input bit en,
                       input bit edge_ok, input logic [15:0] lim, input bit inject);
        bit commit;
        int exp_wr;
        run_id++;
        prot_limit = lim;
        exp_page   = 9'(page);
        for (int i = 0; i < 64; i++) begin exp_vld[i] = 0; seen[i] = 0; exp_val[i] = '0; end
        for (int k = 0; k < n; k++) begin
            exp_val[(off + k) % 64] = pat(run_id, k);
            exp_vld[(off + k) % 64] = 1'b1;
        end
        commit = en && edge_ok && (n > 0);
        exp_wr = 0;
        if (commit)
            for (int i = 0; i < 64; i++)
                if (exp_vld[i] && ((page * 64 + i) < int'(lim))) exp_wr++;
        wr_cnt = 0; busy_cnt = 0; clr_cnt = 0;

        @(negedge clk);
        wen = en; wr_start = 1'b1; wr_addr = ADDR_W'(page * 64 + off);
        @(negedge clk);
        wr_start = 1'b0;
        for (int k = 0; k < n; k++) begin
            byte_valid = 1'b1; byte_data = pat(run_id, k);
            @(negedge clk);
        end
        byte_valid = 1'b0;
        cs_rise = 1'b1; cs_on_byte_edge = edge_ok;
        @(negedge clk);
        cs_rise = 1'b0; cs_on_byte_edge = 1'b0;
        if (inject) begin
            repeat (5) @(negedge clk);
            wen = 1'b1; wr_start = 1'b1; wr_addr = 15'h0005;
            @(negedge clk);
            wr_start = 1'b0;
            for (int k = 0; k < 3; k++) begin
                byte_valid = 1'b1; byte_data = 8'hA5;
                @(negedge clk);
            end
            byte_valid = 1'b0; cs_rise = 1'b1; cs_on_byte_edge = 1'b1;
            @(negedge clk);
            cs_rise = 1'b0; cs_on_byte_edge = 1'b0;
        end
        repeat (inject ? 2 * BUSY + 20 : BUSY + 10) @(negedge clk);
        check(wr_cnt == exp_wr, "R6/R7 write count", wr_cnt, exp_wr);
        check(busy_cnt == (commit ? BUSY : 0), "R5 busy length", busy_cnt, commit ? BUSY : 0);
        check(clr_cnt == (commit ? 1 : 0), "R8 clear pulses", clr_cnt, commit ? 1 : 0);
        check(!busy, "R5 idle after", int'(busy), 0);
        wen = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(!busy && !arr_we && !wen_clear, "R5 reset state",
              int'({busy, arr_we, wen_clear}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !arr_we && !wen_clear, "R5 after reset",
              int'({busy, arr_we, wen_clear}), 0);
        // R1: write-enable low
        run(5, 4, 3, 1'b0, 1'b1, 16'h8000, 1'b0);
        // R4: chip-select rise off a byte boundary
        run(10, 7, 4, 1'b1, 1'b0, 16'h8000, 1'b0);
        // R4: no data byte at all
        run(10, 7, 0, 1'b1, 1'b1, 16'h8000, 1'b0);
        // R2: simple burst
        run(5, 4, 3, 1'b1, 1'b1, 16'h8000, 1'b0);
        // R3: wrap past a full page
        run(60, 100, 70, 1'b1, 1'b1, 16'h8000, 1'b0);
        // R7: protection limit inside the page
        run(0, 448, 64, 1'b1, 1'b1, 16'(448 * 64 + 32), 1'b0);
        // R7: whole page protected
        run(3, 200, 10, 1'b1, 1'b1, 16'h0000, 1'b0);
        // R9: traffic during busy
        run(20, 9, 8, 1'b1, 1'b1, 16'h8000, 1'b1);
        // sweep of offsets, lengths and limits (R2 R3 R6 R7)
        for (int oi = 0; oi < 6; oi++) begin
            for (int li = 0; li < 5; li++) begin
                automatic int offs[6] = '{0, 13, 27, 40, 59, 63};
                automatic int lens[5] = '{1, 2, 31, 64, 130};
                automatic int pg = 300 + oi * 5 + li;
                automatic logic [15:0] lim = (li % 2 == 1) ? 16'(pg * 64 + 16 + oi * 7) : 16'h8000;
                run(offs[oi], pg, lens[li], 1'b1, 1'b1, lim, 1'b0);
            end
        end
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule